// File: doc/BRIEF.md
# Reset Pin Hold-Duration Meter

This block measures how long an external active-low reset button stays pressed. The pin is first brought into the local clock domain. While the synchronized pin reads low, a saturating counter advances once per reference-clock period, which is 40 ns at the default 25 MHz. When the pin is released the counter stops and keeps its value. It returns to zero only when software writes a one into the clear bit of the length register. Because of this, boot software can read the length of the last press, or of several presses added together, well after the button has been let go.

A comparator checks the held count against a programmed number of seconds. It raises a long-press flag once the count reaches that many seconds' worth of reference ticks, and software can use the flag to start a factory-reset routine. A threshold of zero turns the flag off. The meter does not distribute the reset and does not act on the flag.

Top module: `rst_hold_meter`

## Requirements
- R1: The pin passes through two flops. A low level applied before rising edge k increments the count first at rising edge k+2.
- R2: While the synchronized pin is low and no clear is written, the count increases by exactly one on every clock.
- R3: At its all-ones value (CNT_W bits) the count holds and does not wrap.
- R4: While the synchronized pin is high the count keeps its value. A later press continues from that value.
- R5: A write (`wr_en`=1) with `wr_data[31]`=1 sets the count to zero at the next edge. A write with bit 31 at 0 leaves the count unchanged.
- R6: When a clear and an increment fall in the same cycle, the clear wins and the count becomes zero.
- R7: `rd_data[CNT_W-1:0]` carries the count, and every bit of `rd_data` above it reads zero.
- R8: `long_press` is 1 exactly when the count is at least TICKS_PER_SEC times the threshold. A threshold change takes effect one cycle later.
- R9: A threshold of zero seconds keeps `long_press` at 0 from the cycle after it is applied.
- R10: During and after reset the count is zero and `long_press` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| ext_rst_n | input | 1 | External reset button pin, active low, asynchronous |
| wr_en | input | 1 | Write strobe for the length register |
| wr_data | input | 32 | Write data; bit 31 is the clear bit |
| hold_limit_sec | input | THR_W | Long-press threshold in seconds, 0 disables |
| rd_data | output | 32 | Length register read value |
| long_press | output | 1 | Count has reached the threshold |

## Verification
The assertions assume that `hold_limit_sec`, `wr_en` and `wr_data` are synchronous to `clk` and change only between edges. Only the button pin may arrive asynchronously. The two-stage relation of R1 is checked only once two cycles have passed since reset, so pin values seen during reset are never compared. The bench drives every input on the falling edge and holds the threshold steady while checking the flag. It uses a short tick period and a narrow counter so that saturation and the flag boundary fall within a short run.

// File: rtl/rhm_pkg.sv
package rhm_pkg;
    // default geometry of the length counter
    localparam int DEF_CNT_W   = 29;
    localparam int DEF_TICKS   = 25_000_000;
    localparam int DEF_THR_W   = 5;
    localparam int REG_W       = 32;
    localparam int CLR_BIT     = 31;

    // command presented to the counter each cycle
    typedef struct packed {
        logic clr;
        logic inc;
    } cnt_cmd_t;
endpackage

// File: rtl/rhm_sync.sv
module rhm_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic pin_low
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin_n;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: 1'b1, s2: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_low = ~st_q.s2;
endmodule

// File: rtl/rhm_counter.sv
module rhm_counter
    import rhm_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_cmd_t         cmd,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd.clr) begin
            st_d.cnt = '0;
        end else if (cmd.inc && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;
endmodule

// File: rtl/rhm_limit.sv
module rhm_limit
    import rhm_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W,
    parameter int TICKS = DEF_TICKS,
    parameter int THR_W = DEF_THR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [THR_W-1:0] thr_sec,
    input  logic [CNT_W-1:0] count,
    output logic             hit
);
    localparam int TK_W  = $clog2(TICKS + 1);
    localparam int LIM_W = TK_W + THR_W;
    localparam int CMP_W = (LIM_W > CNT_W) ? LIM_W : CNT_W;

    typedef struct packed {
        logic [CMP_W-1:0] lim;
        logic             armed;
    } lim_st_t;

    lim_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.lim   = CMP_W'(TICKS) * CMP_W'(thr_sec);
        st_d.armed = |thr_sec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit = st_q.armed && (CMP_W'(count) >= st_q.lim);
endmodule

// File: rtl/rst_hold_meter.sv
module rst_hold_meter
    import rhm_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W,
    parameter int TICKS = DEF_TICKS,
    parameter int THR_W = DEF_THR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_rst_n,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    input  logic [THR_W-1:0] hold_limit_sec,
    output logic [31:0]      rd_data,
    output logic             long_press
);
    localparam int PAD_W = REG_W - CNT_W;

    logic             pin_low;
    cnt_cmd_t         cmd;
    logic [CNT_W-1:0] count;
    logic             unused_wr_bits;

    rhm_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n   (ext_rst_n),
        .pin_low (pin_low)
    );

    always_comb begin
        cmd.clr = wr_en & wr_data[CLR_BIT];
        cmd.inc = pin_low;
    end

    assign unused_wr_bits = ^wr_data[CLR_BIT-1:0];

    rhm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd),
        .count (count)
    );

    rhm_limit #(.CNT_W(CNT_W), .TICKS(TICKS), .THR_W(THR_W)) u_lim (
        .clk     (clk),
        .rst_n   (rst_n),
        .thr_sec (hold_limit_sec),
        .count   (count),
        .hit     (long_press)
    );

    assign rd_data = {{PAD_W{1'b0}}, count};
endmodule

// File: rtl/rhm_checker.sv
module rhm_checker #(
    parameter int CNT_W = 29,
    parameter int THR_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pin_n,
    input logic             pin_low,
    input logic             wr_en,
    input logic [31:0]      wr_data,
    input logic [THR_W-1:0] thr,
    input logic [31:0]      rd_data,
    input logic             long_press
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt;
    logic             clr;
    logic [1:0]       age_q;

    assign cnt = rd_data[CNT_W-1:0];
    assign clr = wr_en & wr_data[31];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= 2'd0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    // R1: synchronized level equals the pin two edges earlier
    assert_sync_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (pin_low == !$past(pin_n, 2)));

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && pin_low && cnt != CMAX) |=> (cnt == $past(cnt) + 1'b1));

    assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt == CMAX) |=> (cnt == CMAX));

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !pin_low) |=> $stable(cnt));

    // R5 and R6: a clear always zeroes the count, counting or not
    assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    assert_zero_thr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (thr == '0) |=> !long_press);
endmodule

bind rst_hold_meter rhm_checker #(.CNT_W(CNT_W), .THR_W(THR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_n      (ext_rst_n),
    .pin_low    (pin_low),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .thr        (hold_limit_sec),
    .rd_data    (rd_data),
    .long_press (long_press)
);

// File: tb/rst_hold_meter_bench.sv
module rst_hold_meter_bench;
    localparam int CNT_W = 8;
    localparam int TICKS = 10;
    localparam int THR_W = 5;
    localparam longint MAXV = (64'd1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ext_rst_n = 1'b1;
    logic             wr_en = 1'b0;
    logic [31:0]      wr_data = '0;
    logic [THR_W-1:0] thr = '0;
    logic [31:0]      rd_data;
    logic             long_press;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;
    string tag  = "R10";

    // reference model state
    int     m_s1 = 1, m_s2 = 1;
    longint m_cnt = 0, m_lim = 0;
    bit     m_nz = 0;

    always #2 clk = ~clk;

    rst_hold_meter #(.CNT_W(CNT_W), .TICKS(TICKS), .THR_W(THR_W)) u_rst_hold_meter (
        .clk            (clk),
        .rst_n          (rst_n),
        .ext_rst_n      (ext_rst_n),
        .wr_en          (wr_en),
        .wr_data        (wr_data),
        .hold_limit_sec (thr),
        .rd_data        (rd_data),
        .long_press     (long_press)
    );

    task automatic model_edge(input bit pin, input bit wr, input logic [31:0] d, input int th);
        longint nxt;
        nxt = m_cnt;
        if (wr && d[31]) nxt = 0;
        else if (m_s2 == 0 && m_cnt < MAXV) nxt = m_cnt + 1;
        m_cnt = nxt;
        m_s2  = m_s1;
        m_s1  = pin;
        m_lim = longint'(TICKS) * th;
        m_nz  = (th != 0);
    endtask

    task automatic compare();
        bit ef;
        ef = m_nz && (m_cnt >= m_lim);
        vectors++;
        if (rd_data !== 32'(m_cnt) || long_press !== ef) begin
            errors++;
            $display("FAIL %s: rd_data=%0h flag=%0b expected rd_data=%0h flag=%0b",
                     tag, rd_data, long_press, 32'(m_cnt), ef);
        end
    endtask

    task automatic check(input string req, input longint exp_cnt, input bit exp_flag);
        vectors++;
        if (rd_data !== 32'(exp_cnt) || long_press !== exp_flag) begin
            errors++;
            $display("FAIL %s: rd_data=%0h flag=%0b expected rd_data=%0h flag=%0b",
                     req, rd_data, long_press, 32'(exp_cnt), exp_flag);
        end
    endtask

    // called just after a falling edge: drive, clock, compare
    task automatic step(input bit pin, input bit wr, input logic [31:0] d);
        int th;
        ext_rst_n = pin;
        wr_en     = wr;
        wr_data   = d;
        th        = int'(thr);
        @(posedge clk);
        model_edge(pin, wr, d, th);
        @(negedge clk);
        compare();
    endtask

    task automatic run(input int n, input bit pin);
        for (int i = 0; i < n; i++) step(pin, 1'b0, 32'h0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        // R10: pin held low during reset has no effect
        ext_rst_n = 1'b0;
        thr = 5'd3;
        repeat (3) @(negedge clk);
        check("R10", 0, 1'b0);
        ext_rst_n = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        m_lim = 30; m_nz = 1;
        check("R10", 0, 1'b0);

        // R1: two-cycle synchronizer latency
        tag = "R1";
        run(2, 1'b0);
        check("R1", 0, 1'b0);
        run(1, 1'b0);
        check("R1", 1, 1'b0);

        // R2 and R8: steady counting crosses the 30-tick limit
        tag = "R2";
        run(28, 1'b0);
        check("R8", 29, 1'b0);
        tag = "R8";
        run(1, 1'b0);
        check("R8", 30, 1'b1);
        run(1, 1'b0);
        check("R2", 31, 1'b1);

        // R4: release, two in-flight increments, then hold
        tag = "R4";
        run(6, 1'b1);
        check("R4", 33, 1'b1);
        run(10, 1'b0);
        check("R4", 41, 1'b1);
        run(4, 1'b1);
        check("R4", 43, 1'b1);

        // R5: write without the clear bit is ignored, with it clears
        tag = "R5";
        step(1'b1, 1'b1, 32'h7FFF_FFFF);
        check("R5", 43, 1'b1);
        step(1'b1, 1'b1, 32'h8000_0000);
        check("R5", 0, 1'b0);
        step(1'b1, 1'b0, 32'hFFFF_FFFF);
        check("R5", 0, 1'b0);

        // R6: clear in the same cycle as an increment
        tag = "R6";
        run(8, 1'b0);
        check("R6", 6, 1'b0);
        step(1'b0, 1'b1, 32'h8000_0000);
        check("R6", 0, 1'b0);
        run(1, 1'b0);
        check("R6", 1, 1'b0);

        // R9: zero threshold disables the flag above the old limit
        tag = "R9";
        thr = 5'd0;
        run(40, 1'b0);
        check("R9", 41, 1'b0);

        // R3 and R7: saturate at all ones, upper bits read zero
        tag = "R3";
        run(300, 1'b0);
        check("R3", MAXV, 1'b0);
        tag = "R7";
        run(3, 1'b0);
        vectors++;
        if (rd_data[31:CNT_W] !== '0) begin
            errors++;
            $display("FAIL R7: upper=%0h expected 0", rd_data[31:CNT_W]);
        end

        // R8: threshold above full scale never flags; one below flags
        tag = "R8";
        thr = 5'd31;
        run(3, 1'b1);
        check("R8", MAXV, 1'b0);
        thr = 5'd25;
        run(1, 1'b1);
        check("R8", MAXV, 1'b1);

        // R3 again: clear from saturation and restart
        tag = "R3";
        step(1'b1, 1'b1, 32'h8000_0000);
        check("R3", 0, 1'b0);
        run(5, 1'b0);
        check("R1", 3, 1'b0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule